// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block takes a single asynchronous serial line and turns it into parallel characters. It runs on the system clock. A tick enable, pulsed sixteen times per bit period by a baud generator outside the block, paces all sampling. The input passes through a short synchronizer. An edge detector then watches for a high-to-low transition. Each such edge is only a candidate start bit: the receiver samples the line on eight consecutive ticks, and rejects the candidate if any of those samples reads high.

After a start bit is accepted, the receiver samples each data bit, the optional parity bit and a single stop bit once, at the centre of the bit. It collects from 5 to 8 data bits, least significant first. The finished character goes into a holding register with a ready flag and with its own parity-error and framing-error flags. A read strobe clears the ready flag. A character that arrives while the previous one is still unread raises an overrun flag.

A missing stop bit on a non-zero character is handled as follows. If the line stays low for a further half bit, the low stop slot is taken as the start bit of the next character, without waiting for the line to go idle.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, rx_data is 0x00 and rx_ready, rx_perr, rx_ferr and rx_ovr are all low.
- R2: A low pulse on rxd shorter than eight ticks is discarded and produces no character.
- R3: With cfg_len = 2'b11, eight data bits are assembled least significant bit first and presented on rx_data.
- R4: cfg_len selects 5, 6, 7 or 8 data bits for codes 00, 01, 10, 11. For shorter characters, the unused upper bits of rx_data read as zero.
- R5: cfg_par selects no parity (00 or 11), even parity (01) or odd parity (10). rx_perr is high when the received parity bit fails that rule.
- R6: A stop bit sampled low gives rx_ferr high with the character.
- R7: After a framing error on a non-zero character, a line that stays low for eight more ticks is taken as a new start bit. The next data bit is then sampled one bit period after the centre of the failed stop bit.
- R8: After a framing error on an all-zero character, the receiver waits for a fresh falling edge, however long the line stays low.
- R9: rx_ready rises one clock after a character completes. It falls one clock after rd_stb. rx_data and the flags stay unchanged until the next character.
- R10: When a character completes while rx_ready is high and rd_stb is low, rx_ovr is set. rd_stb clears it.
- R11: While rx_en is low, the receiver stays idle and frames on rxd produce no character.
- R12: The receiver hunts for a new start edge right after the stop bit. A frame that follows with no idle time is received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; low holds the receiver idle |
| tick | input | 1 | Oversampling enable, 16 pulses per bit period |
| cfg_len | input | 2 | Data length code: 00=5, 01=6, 10=7, 11=8 bits |
| cfg_par | input | 2 | Parity: 00/11 none, 01 even, 10 odd |
| rxd | input | 1 | Asynchronous serial input, idle high |
| rd_stb | input | 1 | Read strobe for the holding register |
| rx_data | output | 8 | Received character, zero-extended |
| rx_ready | output | 1 | Character available |
| rx_perr | output | 1 | Parity error of the held character |
| rx_ferr | output | 1 | Framing error of the held character |
| rx_ovr | output | 1 | A character was lost to overrun |

## Verification
The hardest case to reach from the ports is the rearm after a framing error. To reach it, the driver sends a non-zero character whose stop slot is held low. It then sends the data bits of a second character straight after that slot, with no start bit of their own. The scoreboard expects both characters: the first with the framing flag set, the second clean. The case is checked against an all-zero character with a low stop bit, followed by a long low stretch. There the scoreboard expects exactly one character until a genuine falling edge arrives.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int MAX_BITS = 8;
    localparam int MIN_BITS = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_REARM
    } srx_state_e;

    localparam logic [1:0] PAR_EVEN = 2'b01;
    localparam logic [1:0] PAR_ODD  = 2'b10;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout,
    output logic fall
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d       = q;
        d.chain = {q.chain[STAGES-2:0], din};
        d.prev  = q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{chain: '1, prev: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign dout = q.chain[STAGES-1];
    assign fall = q.prev & ~q.chain[STAGES-1];

endmodule

// File: rtl/srx_fsm.sv
module srx_fsm
    import srx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                tick,
    input  logic                rx_s,
    input  logic                rx_fall,
    input  logic [1:0]          len_code,
    input  logic [1:0]          par_code,
    output logic                load,
    output logic [MAX_BITS-1:0] load_data,
    output logic                load_perr,
    output logic                load_ferr,
    output logic                idle
);

    localparam int CNT_W = $clog2(OSR);
    localparam int HALF  = OSR / 2;
    localparam int IDX_W = $clog2(MAX_BITS);
    localparam logic [CNT_W-1:0] CNT_HALF_END = CNT_W'(HALF - 1);
    localparam logic [CNT_W-1:0] CNT_FULL_END = CNT_W'(OSR - 1);
    localparam logic [CNT_W-1:0] CNT_MID      = CNT_W'(HALF);

    typedef struct packed {
        srx_state_e          st;
        logic [CNT_W-1:0]    cnt;
        logic [IDX_W-1:0]    bit_idx;
        logic [MAX_BITS-1:0] shreg;
        logic                perr;
    } fsm_t;

    fsm_t q, d;

    logic             par_on;
    logic             par_odd;
    logic [IDX_W-1:0] last_idx;

    assign par_on   = (par_code == PAR_EVEN) || (par_code == PAR_ODD);
    assign par_odd  = (par_code == PAR_ODD);
    assign last_idx = IDX_W'(MIN_BITS - 1) + IDX_W'(len_code);

    always_comb begin
        d         = q;
        load      = 1'b0;
        load_ferr = 1'b0;
        if (!en) begin
            d.st  = ST_IDLE;
            d.cnt = '0;
        end else begin
            unique case (q.st)
                ST_IDLE: begin
                    if (rx_fall) begin
                        d.st  = ST_START;
                        d.cnt = '0;
                    end
                end
                ST_START, ST_REARM: begin
                    if (tick) begin
                        if (rx_s) begin
                            d.st = ST_IDLE;
                        end else if (q.cnt == CNT_HALF_END) begin
                            d.st      = ST_DATA;
                            d.cnt     = (q.st == ST_REARM) ? CNT_MID : '0;
                            d.bit_idx = '0;
                            d.shreg   = '0;
                            d.perr    = 1'b0;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (tick) begin
                        if (q.cnt == CNT_FULL_END) begin
                            d.cnt              = '0;
                            d.shreg[q.bit_idx] = rx_s;
                            if (q.bit_idx == last_idx) begin
                                d.st = par_on ? ST_PAR : ST_STOP;
                            end else begin
                                d.bit_idx = q.bit_idx + 1'b1;
                            end
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                ST_PAR: begin
                    if (tick) begin
                        if (q.cnt == CNT_FULL_END) begin
                            d.cnt  = '0;
                            d.perr = (^q.shreg) ^ rx_s ^ par_odd;
                            d.st   = ST_STOP;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                ST_STOP: begin
                    if (tick) begin
                        if (q.cnt == CNT_FULL_END) begin
                            d.cnt     = '0;
                            load      = 1'b1;
                            load_ferr = ~rx_s;
                            d.st      = (!rx_s && (|q.shreg)) ? ST_REARM : ST_IDLE;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cnt: '0, bit_idx: '0, shreg: '0, perr: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign load_data = q.shreg;
    assign load_perr = q.perr;
    assign idle      = (q.st == ST_IDLE);

endmodule

// File: rtl/srx_hold.sv
module srx_hold
    import srx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [MAX_BITS-1:0] ld_data,
    input  logic                ld_perr,
    input  logic                ld_ferr,
    input  logic                rd_stb,
    output logic [MAX_BITS-1:0] data,
    output logic                ready,
    output logic                perr,
    output logic                ferr,
    output logic                ovr
);

    typedef struct packed {
        logic [MAX_BITS-1:0] data;
        logic                ready;
        logic                perr;
        logic                ferr;
        logic                ovr;
    } hold_t;

    hold_t q, d;

    always_comb begin
        d = q;
        if (load) begin
            d.data  = ld_data;
            d.perr  = ld_perr;
            d.ferr  = ld_ferr;
            d.ready = 1'b1;
            d.ovr   = q.ready && !rd_stb;
        end else if (rd_stb) begin
            d.ready = 1'b0;
            d.ovr   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign data  = q.data;
    assign ready = q.ready;
    assign perr  = q.perr;
    assign ferr  = q.ferr;
    assign ovr   = q.ovr;

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import srx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_en,
    input  logic                tick,
    input  logic [1:0]          cfg_len,
    input  logic [1:0]          cfg_par,
    input  logic                rxd,
    input  logic                rd_stb,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_ready,
    output logic                rx_perr,
    output logic                rx_ferr,
    output logic                rx_ovr
);

    logic                rx_s;
    logic                rx_fall;
    logic                fsm_load;
    logic [MAX_BITS-1:0] fsm_data;
    logic                fsm_perr;
    logic                fsm_ferr;
    logic                fsm_idle;

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rxd),
        .dout  (rx_s),
        .fall  (rx_fall)
    );

    srx_fsm #(.OSR(OSR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (rx_en),
        .tick      (tick),
        .rx_s      (rx_s),
        .rx_fall   (rx_fall),
        .len_code  (cfg_len),
        .par_code  (cfg_par),
        .load      (fsm_load),
        .load_data (fsm_data),
        .load_perr (fsm_perr),
        .load_ferr (fsm_ferr),
        .idle      (fsm_idle)
    );

    srx_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (fsm_load),
        .ld_data (fsm_data),
        .ld_perr (fsm_perr),
        .ld_ferr (fsm_ferr),
        .rd_stb  (rd_stb),
        .data    (rx_data),
        .ready   (rx_ready),
        .perr    (rx_perr),
        .ferr    (rx_ferr),
        .ovr     (rx_ovr)
    );

endmodule

// File: rtl/srx_checker.sv
module srx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_en,
    input logic       rd_stb,
    input logic [1:0] cfg_len,
    input logic       load,
    input logic       fsm_idle,
    input logic [7:0] rx_data,
    input logic       rx_ready,
    input logic       rx_ovr
);

    assert_disabled_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> fsm_idle);

    assert_ready_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> rx_ready);

    assert_ready_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !load) |=> !rx_ready);

    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(rx_data));

    assert_overrun_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (load && rx_ready && !rd_stb) |=> rx_ovr);

    assert_overrun_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !load) |=> !rx_ovr);

    assert_short_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && cfg_len == 2'b00) |=> (rx_data[7:5] == 3'b000));

endmodule

bind serial_rx_core srx_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .rd_stb   (rd_stb),
    .cfg_len  (cfg_len),
    .load     (fsm_load),
    .fsm_idle (fsm_idle),
    .rx_data  (rx_data),
    .rx_ready (rx_ready),
    .rx_ovr   (rx_ovr)
);

// File: tb/serial_rx_core_bench.sv
module serial_rx_core_bench;

    localparam int BIT_CLK = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] cfg_len = 2'b11;
    logic [1:0] cfg_par = 2'b00;
    logic       rxd = 1'b1;
    logic       rd_stb = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready;
    logic       rx_perr;
    logic       rx_ferr;
    logic       rx_ovr;

    typedef struct {
        logic [7:0] d;
        logic       pe;
        logic       fe;
        logic       ov;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   auto_rd = 1'b1;
    bit   done = 1'b0;

    serial_rx_core u_serial_rx_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_en    (rx_en),
        .tick     (tick),
        .cfg_len  (cfg_len),
        .cfg_par  (cfg_par),
        .rxd      (rxd),
        .rd_stb   (rd_stb),
        .rx_data  (rx_data),
        .rx_ready (rx_ready),
        .rx_perr  (rx_perr),
        .rx_ferr  (rx_ferr),
        .rx_ovr   (rx_ovr)
    );

    always #5 clk = ~clk;

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever a character is ready, then reads it
    always @(negedge clk) begin
        if (rd_stb) begin
            rd_stb = 1'b0;
        end else if (rst_n && rx_ready && auto_rd) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "unexpected character (R2/R8/R11)", {24'h0, rx_data}, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rx_data == e.d, {e.tag, " data"}, {24'h0, rx_data}, {24'h0, e.d});
                check({rx_perr, rx_ferr, rx_ovr} == {e.pe, e.fe, e.ov}, {e.tag, " flags pe/fe/ov"},
                      {29'h0, rx_perr, rx_ferr, rx_ovr}, {29'h0, e.pe, e.fe, e.ov});
            end
            rd_stb = 1'b1;
        end
    end

    task automatic drive_bit(input logic v);
        rxd = v;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] dat, input int nbits, input logic [1:0] pc,
                              input bit bad_par, input logic stop_v, input bit with_start,
                              input bit push, input bit ov, input string tag);
        logic [7:0] mask;
        logic       pbit;
        bit         par_on;
        exp_t       e;
        mask    = 8'hFF >> (8 - nbits);
        par_on  = (pc == 2'b01) || (pc == 2'b10);
        pbit    = ^(dat & mask);
        if (pc == 2'b10) pbit = ~pbit;
        if (bad_par) pbit = ~pbit;
        cfg_len = 2'(nbits - 5);
        cfg_par = pc;
        if (push) begin
            e.d = dat & mask; e.pe = par_on && bad_par; e.fe = ~stop_v; e.ov = ov; e.tag = tag;
            exp_q.push_back(e);
        end
        if (with_start) drive_bit(1'b0);
        for (int i = 0; i < nbits; i++) drive_bit(dat[i]);
        if (par_on) drive_bit(pbit);
        drive_bit(stop_v);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check({rx_data, rx_ready, rx_perr, rx_ferr, rx_ovr} == 12'h0, "R1 reset state",
              {20'h0, rx_data, rx_ready, rx_perr, rx_ferr, rx_ovr}, 32'h0);
        rst_n = 1'b1;
        repeat (2 * BIT_CLK) @(negedge clk);

        // R3 / R12: eight-bit frames back to back
        send_frame(8'hA5, 8, 2'b00, 0, 1, 1, 1, 0, "R3 lsb-first A5");
        send_frame(8'h3C, 8, 2'b00, 0, 1, 1, 1, 0, "R12 back-to-back 3C");
        send_frame(8'hFF, 8, 2'b11, 0, 1, 1, 1, 0, "R3 all ones");
        send_frame(8'h01, 8, 2'b00, 0, 1, 1, 1, 0, "R12 back-to-back 01");
        drive_bit(1'b1);

        // R4: shorter lengths
        send_frame(8'hFF, 5, 2'b00, 0, 1, 1, 1, 0, "R4 five bits");
        send_frame(8'hAA, 6, 2'b00, 0, 1, 1, 1, 0, "R4 six bits");
        send_frame(8'hD3, 7, 2'b00, 0, 1, 1, 1, 0, "R4 seven bits");
        drive_bit(1'b1);

        // R5: parity
        send_frame(8'h5B, 8, 2'b01, 0, 1, 1, 1, 0, "R5 even ok");
        send_frame(8'h5B, 8, 2'b01, 1, 1, 1, 1, 0, "R5 even bad");
        send_frame(8'h17, 7, 2'b10, 0, 1, 1, 1, 0, "R5 odd ok");
        send_frame(8'h17, 7, 2'b10, 1, 1, 1, 1, 0, "R5 odd bad");
        drive_bit(1'b1);

        // R6 / R8: zero character, stop low, long low line, then a normal frame
        send_frame(8'h00, 8, 2'b00, 0, 0, 1, 1, 0, "R6 zero char framing");
        repeat (3) drive_bit(1'b0);
        drive_bit(1'b1);
        drive_bit(1'b1);
        send_frame(8'h5A, 8, 2'b00, 0, 1, 1, 1, 0, "R8 after low line");
        drive_bit(1'b1);

        // R7: non-zero framing error, stop slot becomes the next start bit
        send_frame(8'h3C, 8, 2'b00, 0, 0, 1, 1, 0, "R7 framing nonzero");
        send_frame(8'hA5, 8, 2'b00, 0, 1, 0, 1, 0, "R7 rearmed char");
        drive_bit(1'b1);
        drive_bit(1'b1);

        // R2: short low glitches
        rxd = 1'b0; repeat (12) @(negedge clk); rxd = 1'b1;
        repeat (2 * BIT_CLK) @(negedge clk);
        rxd = 1'b0; repeat (24) @(negedge clk); rxd = 1'b1;
        repeat (12 * BIT_CLK) @(negedge clk);
        check(rx_ready == 1'b0 && exp_q.size() == 0, "R2 glitch ignored", {31'h0, rx_ready}, 32'h0);

        // R11: disabled receiver
        rx_en = 1'b0;
        send_frame(8'h66, 8, 2'b00, 0, 1, 1, 0, 0, "R11 disabled");
        repeat (2 * BIT_CLK) @(negedge clk);
        check(rx_ready == 1'b0, "R11 disabled no char", {31'h0, rx_ready}, 32'h0);
        rx_en = 1'b1;
        repeat (BIT_CLK) @(negedge clk);

        // R10: overrun
        auto_rd = 1'b0;
        send_frame(8'h11, 8, 2'b00, 0, 1, 1, 0, 0, "R10 first");
        drive_bit(1'b1);
        check(rx_ready == 1'b1 && rx_ovr == 1'b0, "R9 ready held unread", {30'h0, rx_ready, rx_ovr}, 32'h2);
        send_frame(8'h22, 8, 2'b00, 0, 1, 1, 1, 1, "R10 overrun second");
        drive_bit(1'b1);
        auto_rd = 1'b1;
        repeat (4) @(negedge clk);
        check(rx_ready == 1'b0 && rx_ovr == 1'b0, "R9 R10 cleared by read", {30'h0, rx_ready, rx_ovr}, 32'h0);
        send_frame(8'h33, 8, 2'b00, 0, 1, 1, 1, 0, "R10 ovr gone");
        repeat (3 * BIT_CLK) @(negedge clk);

        check(exp_q.size() == 0, "all requirements: scoreboard drained", exp_q.size(), 32'h0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule